// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gating

This block decides, cycle by cycle, how each clock output of a clock generator behaves: it either toggles, sits in a driven stopped level, or is released to high impedance. One fast input clock is divided into six rate classes: CPU, SRC, PCI, DOT, USB and REF. Every output is gated from the divided phase of its class. The decision is made per output from its enable bit, its stop-select bit (stoppable or free-running), a global stop bit, a drive-mode bit for stopped SRC pairs, per-group drive-mode bits for power-down, and an asynchronous active-high power-down input. The power-down input is passed through a two-flop synchronizer before it gates anything.

There are 21 outputs, indexed as follows. Indices 0-5 are the PCI outputs and 6-8 are the free-running PCI outputs. Indices 9-14 are the SRC pairs. Index 15 is a shared pair. Indices 16-17 are the CPU pairs, 18 is the DOT pair, 19 is USB and 20 is REF. Indices 9 to 18 are differential. The shared pair takes its role from a strap that is captured while reset is high. In CPU role it uses the CPU rate, ignores the global stop, and takes its own power-down drive bit. In SRC role it behaves like the other SRC pairs.

Any change between running and not running is taken only while the source phase is low. A high pulse is therefore never cut short, and a low gap is never shorter than a half period.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is high, every output is stopped and driven. The true leg `clk_t` is 0. The complement leg `clk_c` is 1 on differential outputs (indices 9-18) and 0 on single-ended ones. `clk_oe` is 1 and the mode code is HOLD (00).
- R2: When `glb_stop` is 1, each output with index 0-15 whose `stop_sel` bit is 1 stops. Outputs with `stop_sel` 0 keep toggling, and so do the CPU, DOT, USB and REF outputs (indices 16-20).
- R3: A stopped SRC pair (indices 9-14, or 15 in SRC role) is driven with true 0 and complement 1 when `stop_hiz` is 0, and is in Hi-Z (`clk_oe` 0) when `stop_hiz` is 1. A stopped PCI output (indices 0-8) is always driven low.
- R4: An output whose `out_en` bit is 0 is held driven and stopped, whatever the stop and drive-mode bits say. Power-down still overrides this.
- R5: While power-down is active, every output stops. The SRC pairs follow `pd_hiz_src`, each CPU pair follows its `pd_hiz_cpu` bit, and the shared pair in CPU role follows `pd_hiz_itp`. In each of these bits, 1 means Hi-Z and 0 means driven. DOT, USB, REF and PCI outputs are driven low.
- R6: `pair_strap` is sampled only while `rst` is 1. A 1 puts the shared pair in CPU role: CPU rate, immune to `glb_stop`, power-down drive from `pd_hiz_itp`. A 0 puts it in SRC role. A change of the strap after reset has no effect.
- R7: Every high pulse of a running output lasts exactly the half period of its class. The default half periods are CPU 2, SRC 3, PCI 5, DOT 2, USB 4 and REF 7 clock cycles. No low gap is shorter than that half period.
- R8: Power-down is synchronized through two flops. After `pd_async` falls, an enabled CPU pair does not rise before the third clock edge and toggles again within 12 cycles.
- R9: `out_mode[2i+1:2i]` reports the state of output i: RUN = 01, HOLD = 00, HIZ = 10. `clk_oe` is 0 only in HIZ. A running differential output always has `clk_c` equal to the inverse of `clk_t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, source of all divided rates |
| rst | input | 1 | Synchronous active-high reset; also the strap capture window |
| pd_async | input | 1 | Asynchronous active-high power-down |
| pair_strap | input | 1 | Shared-pair role strap: 1 CPU role, 0 SRC role |
| out_en | input | 21 | Per-output enable |
| stop_sel | input | 16 | Per-output stoppable select for indices 0-15 |
| glb_stop | input | 1 | Global stop for stoppable PCI and SRC outputs |
| stop_hiz | input | 1 | Stopped SRC pairs: 0 driven, 1 Hi-Z |
| pd_hiz_src | input | 1 | Power-down drive for the SRC pairs |
| pd_hiz_cpu | input | 2 | Power-down drive for CPU pairs 0 and 1 |
| pd_hiz_itp | input | 1 | Power-down drive for the shared pair in CPU role |
| clk_t | output | 21 | True leg (single-ended output level) |
| clk_c | output | 21 | Complement leg; 0 on single-ended outputs |
| clk_oe | output | 21 | Output driver enable; 0 means Hi-Z |
| out_mode | output | 42 | Per-output state code, two bits per output |

## Verification
A wrong mode register shows up at the ports within one half period of the output's class. The output either keeps toggling when it should stop, freezes at the wrong level, or drops its driver enable. A bad gating instant is harder to see: it shows only as a high pulse shorter than the class half period, or as a low gap shorter than it. For that reason the pulse widths of a slow PCI output and a fast CPU pair are measured while stop and enable are flipped at irregular intervals. A synchronizer that is missing or too deep shows only as a shift in the number of cycles from power-down release to the first CPU edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int N_PCI  = 6;
  localparam int N_PCIF = 3;
  localparam int N_SRC  = 6;
  localparam int N_CPU  = 2;
  localparam int I_PCIF = N_PCI;
  localparam int I_SRC  = I_PCIF + N_PCIF;
  localparam int I_SHR  = I_SRC + N_SRC;
  localparam int I_CPU  = I_SHR + 1;
  localparam int I_DOT  = I_CPU + N_CPU;
  localparam int I_USB  = I_DOT + 1;
  localparam int I_REF  = I_USB + 1;
  localparam int N_OUT  = I_REF + 1;
  localparam int N_STP  = I_SHR + 1;

  localparam int C_CPU = 0;
  localparam int C_SRC = 1;
  localparam int C_PCI = 2;
  localparam int C_DOT = 3;
  localparam int C_USB = 4;
  localparam int C_REF = 5;
  localparam int N_CLS = 6;

  typedef enum logic [1:0] {
    M_HOLD = 2'b00,
    M_RUN  = 2'b01,
    M_HIZ  = 2'b10
  } omode_e;

  function automatic int cls_of(int i);
    if (i < I_SRC) return C_PCI;
    if (i <= I_SHR) return C_SRC;
    if (i < I_DOT) return C_CPU;
    if (i == I_DOT) return C_DOT;
    if (i == I_USB) return C_USB;
    return C_REF;
  endfunction

  function automatic bit is_diff(int i);
    return (i >= I_SRC) && (i <= I_DOT);
  endfunction
endpackage

// File: rtl/clk_rate_div.sv
module clk_rate_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (halt && !phase) begin
      cnt <= '0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_HALT_LOW: assert property (@(posedge clk) disable iff (rst) (halt && !phase) |=> !phase); // R5
endmodule

// File: rtl/stop_mode_req.sv
module stop_mode_req
  import clkgate_pkg::*;
(
  input  logic [N_OUT-1:0]   out_en,
  input  logic [N_STP-1:0]   stop_sel,
  input  logic               glb_stop,
  input  logic               stop_hiz,
  input  logic               pd_hiz_src,
  input  logic [N_CPU-1:0]   pd_hiz_cpu,
  input  logic               pd_hiz_itp,
  input  logic               pd_s,
  input  logic               role_cpu,
  output logic [2*N_OUT-1:0] req
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_req
    logic stp, stp_z, pd_z;
    if (i < I_SRC) begin : g_pci
      assign stp   = stop_sel[i];
      assign stp_z = 1'b0;
      assign pd_z  = 1'b0;
    end else if (i < I_SHR) begin : g_src
      assign stp   = stop_sel[i];
      assign stp_z = stop_hiz;
      assign pd_z  = pd_hiz_src;
    end else if (i == I_SHR) begin : g_shr
      assign stp   = stop_sel[i] & ~role_cpu;
      assign stp_z = stop_hiz;
      assign pd_z  = role_cpu ? pd_hiz_itp : pd_hiz_src;
    end else if (i < I_DOT) begin : g_cpu
      assign stp   = 1'b0;
      assign stp_z = 1'b0;
      assign pd_z  = pd_hiz_cpu[i-I_CPU];
    end else begin : g_other
      assign stp   = 1'b0;
      assign stp_z = 1'b0;
      assign pd_z  = 1'b0;
    end
    assign req[2*i +: 2] = pd_s ? (pd_z ? M_HIZ : M_HOLD) :
                           !out_en[i] ? M_HOLD :
                           (glb_stop && stp) ? (stp_z ? M_HIZ : M_HOLD) : M_RUN;
  end
endmodule

// File: rtl/out_gate_cell.sv
module out_gate_cell
  import clkgate_pkg::*;
#(
  parameter bit IS_DIFF = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase,
  input  logic [1:0] req,
  output logic       q_t,
  output logic       q_c,
  output logic       oe,
  output logic [1:0] mode
);
  omode_e mode_q;
  logic   run;

  assign run  = (mode_q == M_RUN);
  assign mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_HOLD;
      q_t    <= 1'b0;
      q_c    <= IS_DIFF;
      oe     <= 1'b1;
    end else begin
      if (!phase) mode_q <= omode_e'(req);
      q_t <= run & phase;
      q_c <= IS_DIFF & ~(run & phase);
      oe  <= (mode_q != M_HIZ);
    end
  end

  AST_MODE_AT_LOW: assert property (@(posedge clk) disable iff (rst) (mode_q != $past(mode_q)) |-> !$past(phase)); // R7
  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst) !oe |-> !q_t); // R3
  if (IS_DIFF) begin : g_dchk
    AST_PAIR_COMP: assert property (@(posedge clk) disable iff (rst) oe |-> (q_c == ~q_t)); // R9
  end else begin : g_schk
    AST_SE_COMP_LOW: assert property (@(posedge clk) disable iff (rst) !q_c); // R9
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clkgate_pkg::*;
#(
  parameter int HALF_CPU = 2,
  parameter int HALF_SRC = 3,
  parameter int HALF_PCI = 5,
  parameter int HALF_DOT = 2,
  parameter int HALF_USB = 4,
  parameter int HALF_REF = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd_async,
  input  logic               pair_strap,
  input  logic [N_OUT-1:0]   out_en,
  input  logic [N_STP-1:0]   stop_sel,
  input  logic               glb_stop,
  input  logic               stop_hiz,
  input  logic               pd_hiz_src,
  input  logic [N_CPU-1:0]   pd_hiz_cpu,
  input  logic               pd_hiz_itp,
  output logic [N_OUT-1:0]   clk_t,
  output logic [N_OUT-1:0]   clk_c,
  output logic [N_OUT-1:0]   clk_oe,
  output logic [2*N_OUT-1:0] out_mode
);
  logic               pd_m, pd_s, role_cpu;
  logic [N_CLS-1:0]   ph_cls;
  logic [2*N_OUT-1:0] req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_m     <= 1'b0;
      pd_s     <= 1'b0;
      role_cpu <= pair_strap;
    end else begin
      pd_m <= pd_async;
      pd_s <= pd_m;
    end
  end

  for (genvar c = 0; c < N_CLS; c++) begin : g_div
    localparam int H = (c == C_CPU) ? HALF_CPU : (c == C_SRC) ? HALF_SRC :
                       (c == C_PCI) ? HALF_PCI : (c == C_DOT) ? HALF_DOT :
                       (c == C_USB) ? HALF_USB : HALF_REF;
    clk_rate_div #(.HALF(H)) u_div (
      .clk(clk), .rst(rst), .halt(pd_s), .phase(ph_cls[c])
    );
  end

  stop_mode_req u_req (
    .out_en(out_en), .stop_sel(stop_sel), .glb_stop(glb_stop), .stop_hiz(stop_hiz),
    .pd_hiz_src(pd_hiz_src), .pd_hiz_cpu(pd_hiz_cpu), .pd_hiz_itp(pd_hiz_itp),
    .pd_s(pd_s), .role_cpu(role_cpu), .req(req)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic ph;
    if (i == I_SHR) begin : g_shr
      assign ph = role_cpu ? ph_cls[C_CPU] : ph_cls[C_SRC];
    end else begin : g_fix
      assign ph = ph_cls[cls_of(i)];
    end
    out_gate_cell #(.IS_DIFF(is_diff(i))) u_cell (
      .clk(clk), .rst(rst), .phase(ph), .req(req[2*i +: 2]),
      .q_t(clk_t[i]), .q_c(clk_c[i]), .oe(clk_oe[i]), .mode(out_mode[2*i +: 2])
    );
  end

  AST_PD_TWO_STAGE: assert property (@(posedge clk) disable iff (rst) $rose(pd_s) |-> $past(pd_async, 2)); // R8
endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  import clkgate_pkg::*;

  typedef struct packed {
    logic [N_OUT-1:0] en;
    logic [N_STP-1:0] ssel;
    logic gstop;
    logic shz;
    logic pdsrc;
    logic [1:0] pdcpu;
    logic pditp;
    logic pd;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{21'h1FFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
    '{21'h1FFFFF, 16'h0000, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0},
    '{21'h1FFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
    '{21'h1FFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0},
    '{21'h1FFFFF, 16'h5555, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0},
    '{21'h0AAAAA, 16'hFFFF, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0},
    '{21'h1FFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1},
    '{21'h1FFFFF, 16'h0000, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1},
    '{21'h000000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1},
    '{21'h1FFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}
  };
  localparam logic [N_OUT-1:0] DIFF_MASK = 21'h07FE00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_async = 1'b0, pair_strap = 1'b0;
  logic [N_OUT-1:0] out_en = '1;
  logic [N_STP-1:0] stop_sel = '0;
  logic glb_stop = 1'b0, stop_hiz = 1'b0, pd_hiz_src = 1'b0, pd_hiz_itp = 1'b0;
  logic [N_CPU-1:0] pd_hiz_cpu = '0;
  logic [N_OUT-1:0] clk_t, clk_c, clk_oe;
  logic [2*N_OUT-1:0] out_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit role = 1'b0;

  always #10 clk = ~clk;

  clk_stop_gate u_dut (
    .clk(clk), .rst(rst), .pd_async(pd_async), .pair_strap(pair_strap),
    .out_en(out_en), .stop_sel(stop_sel), .glb_stop(glb_stop), .stop_hiz(stop_hiz),
    .pd_hiz_src(pd_hiz_src), .pd_hiz_cpu(pd_hiz_cpu), .pd_hiz_itp(pd_hiz_itp),
    .clk_t(clk_t), .clk_c(clk_c), .clk_oe(clk_oe), .out_mode(out_mode)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(int i, row_t r, bit rl);
    bit stp = 0, sz = 0, pz = 0;
    if (i < I_SRC) stp = r.ssel[i];
    else if (i < I_SHR) begin stp = r.ssel[i]; sz = r.shz; pz = r.pdsrc; end
    else if (i == I_SHR) begin stp = r.ssel[i] && !rl; sz = r.shz; pz = rl ? r.pditp : r.pdsrc; end
    else if (i < I_DOT) pz = r.pdcpu[i-I_CPU];
    if (r.pd) return pz ? 2'b10 : 2'b00;
    if (!r.en[i]) return 2'b00;
    if (r.gstop && stp) return sz ? 2'b10 : 2'b00;
    return 2'b01;
  endfunction

  task automatic drive(input row_t r);
    @(negedge clk);
    out_en = r.en; stop_sel = r.ssel; glb_stop = r.gstop; stop_hiz = r.shz;
    pd_hiz_src = r.pdsrc; pd_hiz_cpu = r.pdcpu; pd_hiz_itp = r.pditp; pd_async = r.pd;
  endtask

  // observe every output for 40 cycles after settling; classify and compare
  task automatic observe(input row_t r, input string tag);
    int tog [N_OUT];
    bit oe0 [N_OUT];
    bit oe1 [N_OUT];
    bit bad [N_OUT];
    logic [N_OUT-1:0] prev;
    repeat (40) @(negedge clk);
    prev = clk_t;
    for (int i = 0; i < N_OUT; i++) begin tog[i] = 0; oe0[i] = 0; oe1[i] = 0; bad[i] = 0; end
    repeat (40) begin
      @(negedge clk);
      for (int i = 0; i < N_OUT; i++) begin
        if (clk_t[i] != prev[i]) tog[i]++;
        if (clk_oe[i]) oe1[i] = 1; else oe0[i] = 1;
        if (clk_oe[i] && DIFF_MASK[i] && clk_c[i] != ~clk_t[i]) bad[i] = 1;
        if (!DIFF_MASK[i] && clk_c[i]) bad[i] = 1;
      end
      prev = clk_t;
    end
    for (int i = 0; i < N_OUT; i++) begin
      logic [1:0] obs, e;
      e = exp_mode(i, r, role);
      if (oe0[i] && !oe1[i]) obs = 2'b10;
      else if (oe0[i] || bad[i]) obs = 2'b11;
      else if (tog[i] > 0) obs = 2'b01;
      else if (!clk_t[i] && clk_c[i] == DIFF_MASK[i]) obs = 2'b00;
      else obs = 2'b11;
      chk(obs == e, tag, $sformatf("observed behaviour of output %0d", i), obs, e);
      chk(out_mode[2*i +: 2] == e, "R9", $sformatf("mode code of output %0d", i), out_mode[2*i +: 2], e);
    end
  endtask

  // pulse-width monitor on PCI0 (half 5) and CPU0 (half 2)
  int hi_len [2], lo_len [2];
  bit prv [2];
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int idx, h;
      idx = (k == 0) ? 0 : I_CPU;
      h = (k == 0) ? 5 : 2;
      if (rst) begin hi_len[k] = 0; lo_len[k] = 0; prv[k] = 0; end
      else begin
        if (clk_t[idx]) begin
          if (!prv[k]) begin
            chk(lo_len[k] >= h, "R7", $sformatf("low gap before rise on %0d", idx), lo_len[k], h);
            lo_len[k] = 0;
          end
          hi_len[k]++;
        end else begin
          if (prv[k]) begin
            chk(hi_len[k] == h, "R7", $sformatf("high pulse width on %0d", idx), hi_len[k], h);
            hi_len[k] = 0;
          end
          lo_len[k]++;
        end
        prv[k] = clk_t[idx];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    row_t r;
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(clk_t == '0, "R1", "true legs in reset", clk_t, 0);
    chk(clk_c == DIFF_MASK, "R1", "complement legs in reset", clk_c, DIFF_MASK);
    chk(clk_oe == '1, "R1", "drivers in reset", clk_oe, 21'h1FFFFF);
    chk(out_mode == '0, "R1", "mode codes in reset", out_mode, 0);
    @(negedge clk) rst = 1'b0;

    // table walk, SRC role: R2 R3 R4 R5 R9
    for (int n = 0; n < NROWS; n++) begin
      drive(ROWS[n]);
      observe(ROWS[n], (n < 2) ? "R2" : (n < 5) ? "R3" : (n == 5) ? "R4" : (n < 9) ? "R5" : "R2");
    end

    // R7: irregular stop/enable flipping with pulse monitors running
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      stop_sel = '1; glb_stop = k[0]; out_en[I_CPU] = ~k[1]; out_en[0] = ~k[2];
      repeat (k % 7) @(negedge clk);
    end
    drive(ROWS[0]);

    // R8: power-down release latency
    r = ROWS[0]; r.pd = 1'b1;
    drive(r);
    repeat (40) @(negedge clk);
    pd_async = 1'b0;
    cnt = 0;
    while (!clk_t[I_CPU] && cnt < 20) begin
      @(negedge clk);
      cnt++;
      if (cnt == 2) chk(!clk_t[I_CPU], "R8", "CPU0 still low two edges after release", clk_t[I_CPU], 0);
    end
    chk(cnt <= 12 && cnt >= 3, "R8", "cycles from release to first CPU0 edge", cnt, 5);

    // R6: strap captured in reset, CPU role
    @(negedge clk); rst = 1'b1; pair_strap = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; role = 1'b1;
    @(negedge clk) pair_strap = 1'b0;
    r = ROWS[3];
    drive(r);
    observe(r, "R6");
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      logic p;
      p = clk_t[I_SHR];
      @(negedge clk);
      if (clk_t[I_SHR] != p) cnt++;
    end
    chk(cnt >= 18, "R6", "shared pair edges at CPU rate after strap change", cnt, 20);
    r = ROWS[0]; r.pd = 1'b1; r.pditp = 1'b1; r.pdsrc = 1'b0;
    drive(r);
    observe(r, "R6");
    r = ROWS[0]; r.pd = 1'b1; r.pditp = 1'b0; r.pdsrc = 1'b1;
    drive(r);
    observe(r, "R5");
    drive(ROWS[0]);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule